// File: doc/BRIEF.md
# Staged Logical Left Shifter

This block moves a 16-bit data word toward its most significant end by a distance taken from a second 16-bit operand word. It is purely combinational: there is no clock and no reset, and the result follows its inputs within the same evaluation. Bits that move past the top of the word are lost. The low positions they leave empty are filled with zeros. The numeric effect is multiplication by 2^b, kept modulo 2^16.

The shifter is a cascade of multiplexer stages. Each stage moves the word by a fixed power of two: 1, 2, 4 and then 8 positions. Bit i of the distance word turns stage i on, so the enabled stages add up to the full distance. Only distances from 0 to 8 are legal. Any larger value in the distance word, including one with upper bits set, makes the output all zeros.

Top module: `lls_shifter`

## Requirements
- R1: For every distance b from 0 to 8, `data_out` equals `data_in` multiplied by 2^b, modulo 2^16.
- R2: With a distance of 0, `data_out` equals `data_in` unchanged.
- R3: Stage i is turned on by bit i of `shift_amt`, where bit 0 is the least significant bit. The stages shift by 1, 2, 4 and 8 positions, in that order from the input side. Each output bit of a stage is a 2-way choice between the same input position and the position 2^i lower.
- R4: An enabled stage that moves by s positions drives its lowest s output bits to 0 and discards its top s input bits. No stage ever sets a bit that was not present at its input.
- R5: Enabled stages combine additively. For example, distance 5 (binary 101) gives the same result as a shift by 1 followed by a shift by 4.
- R6: `data_in` = 0x00A5 with distance 2 gives `data_out` = 0x0294.
- R7: A `shift_amt` value greater than 8 forces `data_out` to 0x0000. This holds for values 9 to 15 and for any value with a bit above bit 3 set.
- R8: `data_out` follows a change of either input with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 16 | Word to be shifted |
| shift_amt | input | 16 | Shift distance; legal values are 0 to 8 |
| data_out | output | 16 | Shifted word, or zero when the distance is out of range |

## Verification
Every distance from 0 to 8 is swept over random words, all-ones and every single-bit pattern. A swapped or missing stage, or stages in the wrong order, would give the wrong power of two on the odd combinations such as 3, 5, 6 and 7. A rotate instead of a shift would show up as ones wrapping into the low bits, and the all-ones pattern exposes it at once. The out-of-range side is probed with 9 to 15, with words whose low nibble is legal but whose upper bits are set, and with 0xFFFF. A guard that looked only at the low nibble would then return a shifted word instead of zero. Changing the inputs between clock edges and checking the output before the next edge catches any stray register in the path.

// File: rtl/lls_pkg.sv
// Package lls_pkg
// Shared defaults for the staged logical left shifter.
// Assumes every consumer derives its own stage count from the maximum distance.
package lls_pkg;
    localparam int unsigned LLS_DATA_W    = 16;
    localparam int unsigned LLS_AMT_W     = 16;
    localparam int unsigned LLS_MAX_SHIFT = 8;

    // Number of power-of-two stages needed to cover 0..max_shift.
    function automatic int unsigned lls_stage_count(input int unsigned max_shift);
        return $clog2(max_shift + 1);
    endfunction
endpackage

// File: rtl/lls_stage.sv
// Module lls_stage
// One shift stage: when en is high, every output bit takes the input bit
// SH positions lower, and the lowest SH bits become zero. When en is low,
// the word passes through unchanged.
// Assumes SH >= 1. Purely combinational.
module lls_stage #(
    parameter int unsigned W  = 16,
    parameter int unsigned SH = 1
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    // One 2-way multiplexer per data bit.
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (b >= SH) begin : g_mux
            assign dout[b] = en ? din[b-SH] : din[b];
        end else begin : g_fill
            assign dout[b] = en ? 1'b0 : din[b];
        end
    end

    // Stage checks: pass-through, zero fill, upper bits kept, no new ones.
    always_comb begin
        if (!$isunknown({en, din, dout})) begin
            p_no_new_ones_r4: assert ($countones(dout) <= $countones(din))
                else $error("stage SH=%0d created a set bit", SH);
            if (!en) begin
                p_pass_through_r2: assert (dout == din)
                    else $error("disabled stage SH=%0d altered data", SH);
            end else begin
                for (int b = 0; b < int'(W); b++) begin
                    if (b < int'(SH)) begin
                        p_zero_fill_r4: assert (dout[b] == 1'b0)
                            else $error("stage SH=%0d bit %0d not zero", SH, b);
                    end else begin
                        p_keep_upper_r3: assert (dout[b] == din[b-int'(SH)])
                            else $error("stage SH=%0d bit %0d wrong source", SH, b);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/lls_range_guard.sv
// Module lls_range_guard
// Raises over when the distance word is above MAX_SHIFT.
// Assumes AMT_W is wider than the stage select field NSEL.
module lls_range_guard #(
    parameter int unsigned AMT_W     = 16,
    parameter int unsigned MAX_SHIFT = 8,
    parameter int unsigned NSEL      = 4
) (
    input  logic [AMT_W-1:0] amt,
    output logic             over
);

    // Compare the whole distance word against the legal maximum.
    always_comb begin
        over = (amt > AMT_W'(MAX_SHIFT));
    end

    // Any set bit above the stage select field must count as out of range.
    always_comb begin
        if (!$isunknown({amt, over})) begin
            if (amt[AMT_W-1:NSEL] != '0) begin
                p_upper_bits_r7: assert (over)
                    else $error("upper distance bits set but not flagged");
            end
        end
    end

endmodule

// File: rtl/lls_shifter.sv
// Module lls_shifter
// Logical left shift of data_in by shift_amt (0..MAX_SHIFT). The shift is
// built from a cascade of power-of-two stages, with stage i enabled by
// shift_amt[i]. A distance above MAX_SHIFT gives a zero result.
// Assumes no clock or reset: the output is a pure function of the inputs.
module lls_shifter
    import lls_pkg::*;
#(
    parameter int unsigned DATA_W    = LLS_DATA_W,
    parameter int unsigned AMT_W     = LLS_AMT_W,
    parameter int unsigned MAX_SHIFT = LLS_MAX_SHIFT
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [AMT_W-1:0]  shift_amt,
    output logic [DATA_W-1:0] data_out
);

    localparam int unsigned NSTG = lls_stage_count(MAX_SHIFT);

    logic [DATA_W-1:0] stage_bus [NSTG+1];
    logic              amt_over;

    assign stage_bus[0] = data_in;

    // Cascade of shift-by-1, 2, 4, 8 ... stages.
    for (genvar i = 0; i < NSTG; i++) begin : g_stage
        lls_stage #(
            .W  (DATA_W),
            .SH (1 << i)
        ) u_stage (
            .en   (shift_amt[i]),
            .din  (stage_bus[i]),
            .dout (stage_bus[i+1])
        );
    end

    lls_range_guard #(
        .AMT_W     (AMT_W),
        .MAX_SHIFT (MAX_SHIFT),
        .NSEL      (NSTG)
    ) u_guard (
        .amt  (shift_amt),
        .over (amt_over)
    );

    // Final select: the cascade result, or zero for an illegal distance.
    always_comb begin
        data_out = amt_over ? '0 : stage_bus[NSTG];
    end

endmodule

// File: tb/sim_lls_shifter.sv
// Bench for lls_shifter. The reference is a behavioural multiply by 2^b
// with a range check. Inputs are driven on the falling edge and compared
// 1 ns later, once per clock.
module sim_lls_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] din = '0;
    logic [15:0] amt = '0;
    logic [15:0] dout;
    int          checks = 0;
    int          fails  = 0;
    int          cycles = 0;

    always #2 clk = ~clk;

    lls_shifter u0 (
        .data_in   (din),
        .shift_amt (amt),
        .data_out  (dout)
    );

    function automatic logic [15:0] ref_model(input logic [15:0] d, input logic [15:0] a);
        longint unsigned v;
        if (a > 16'd8) return 16'h0000;
        v = longint'(d) * (longint'(1) << a);
        return 16'(v % 65536);
    endfunction

    task automatic check(input string tag, input logic [15:0] exp);
        checks++;
        if (dout !== exp) begin
            fails++;
            $display("FAIL %s din=%h amt=%h got=%h exp=%h", tag, din, amt, dout, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [15:0] d, input logic [15:0] a);
        @(negedge clk);
        din = d;
        amt = a;
        #1;
        check(tag, ref_model(d, a));
    endtask

    // Watchdog: an overlong run counts as a failure.
    always @(posedge clk) begin
        if (!rst_n) cycles <= 0;
        else        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] pat;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R2 idle zero", 16'h0000);

        apply("R6 example", 16'h00A5, 16'd2);
        checks++;
        if (dout !== 16'h0294) begin
            fails++;
            $display("FAIL R6 literal got=%h exp=%h", dout, 16'h0294);
        end

        for (int b = 0; b <= 8; b++) begin
            apply("R2 R1 all-ones", 16'hFFFF, 16'(b));
            for (int k = 0; k < 16; k++) apply("R4 single bit", 16'(1 << k), 16'(b));
            for (int n = 0; n < 20; n++) begin
                pat = 16'($urandom());
                apply("R1 random", pat, 16'(b));
            end
        end

        apply("R2 zero distance", 16'h8001, 16'd0);
        apply("R3 stage1 only", 16'hC003, 16'd1);
        apply("R3 stage8 only", 16'h00FF, 16'd8);
        apply("R5 one plus four", 16'h0ABC, 16'd5);
        apply("R5 two plus four", 16'h1357, 16'd6);
        apply("R5 one two four", 16'hFFFF, 16'd7);

        for (int a = 9; a < 16; a++) apply("R7 over low nibble", 16'hFFFF, 16'(a));
        apply("R7 upper bit set", 16'hFFFF, 16'h0010);
        apply("R7 upper with small nibble", 16'h1234, 16'h8001);
        apply("R7 max word", 16'hFFFF, 16'hFFFF);
        apply("R7 bit 4 plus 2", 16'h00A5, 16'h0012);

        // Combinational follow: change mid-cycle, no edge between.
        @(posedge clk);
        #0.5;
        din = 16'h0101;
        amt = 16'd3;
        #0.5;
        check("R8 follows without edge", 16'h0808);
        amt = 16'd0;
        #0.5;
        check("R8 follows amount change", 16'h0101);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule